// File: doc/BRIEF.md
# Floppy Controller Host Register Interface

This block is the processor-facing side of a floppy disk controller. A host reaches five registers through a two-bit address and a read/write strobe. One address is shared: a read there returns status and a write there issues a command. The other three addresses hold the track, sector and data registers, and each can be read and written. The block owns the Busy and Lost Data status bits, the data request (DRQ) line and the interrupt request (INTRQ) line. Reading or writing a register clears these handshakes as a side effect.

Toward the command-execution core, the block gives a one-cycle start pulse together with the latched command byte. It also gives a one-cycle terminate pulse when Force Interrupt stops a running command. The core sends back byte-transfer strobes (a byte delivered from disk, or a byte taken for disk), a completion strobe with four result flags, and load strobes for the track and sector registers.

Force Interrupt (upper nibble 1101) is accepted at any time. It has its own status rules. Its low four bits select which events later raise INTRQ.

Top module: `fdc_hostif`

## Requirements
- R1: Address 01 selects the track register, 10 the sector register and 11 the data register. Each returns on `host_rdata`, in the cycle of the read, the last value loaded into it.
- R2: A read at address 00 returns status, never the command byte. The status bits are:
  - bit 7: not ready, the inverse of `drv_ready`.
  - bits 6..3: the core flags latched at completion.
  - bit 0: Busy.
  - Type I layout: bit 2 is `drv_track0` and bit 1 is `drv_index`.
  - Other layout: bit 2 is Lost Data and bit 1 mirrors DRQ.
  - After reset, Busy is 0, the layout is Type I and the flags are 0.
- R3: A write at address 00 while Busy is 0, of a byte whose upper nibble is not 1101, is accepted. After the next clock edge, `cmd_start` is high for one cycle, `cmd_code` holds the byte, Busy is 1, flags, Lost Data and DRQ are 0, and INTRQ is 0. The layout is Type I when byte bit 7 is 0 and the other layout when it is 1.
- R4: A write at address 00 while Busy is 1, of a byte that is not Force Interrupt, is ignored. No start pulse follows and `cmd_code` is unchanged.
- R5: A core byte event (`core_rx_valid` or `core_tx_take`) sets DRQ. A host read or write of the data register clears DRQ. When both happen in the same cycle, DRQ ends up set.
- R6: A core byte event while DRQ is already set sets Lost Data, unless the host accesses the data register in that same cycle. `core_rx_valid` loads `core_rx_byte` into the data register, and it takes priority over a host data write in the same cycle.
- R7: `core_done` while Busy is 1 clears Busy, latches `core_flags` into status bits 6..3 and raises INTRQ. INTRQ clears on a status read or on an accepted command write.
- R8: Force Interrupt while Busy is 1 clears Busy and pulses `force_term` for one cycle. Flags, Lost Data, DRQ and the layout are left unchanged.
- R9: Force Interrupt while Busy is 0 clears flags, Lost Data and DRQ and selects the Type I layout. It gives no `force_term` pulse.
- R10: Force Interrupt condition bits 3..0 all zero raise no INTRQ. Bit 3 raises INTRQ at once and holds it through status reads until the next accepted command write.
- R11: After Force Interrupt, until the next accepted command write, INTRQ is raised by the following events when their bits are set:
  - bit 2: a rising edge of `drv_index`.
  - bit 1: a falling edge of `drv_ready`.
  - bit 0: a rising edge of `drv_ready`.
- R12: Host writes to the track or sector register while Busy is 1 are ignored. `core_trk_load` and `core_sec_load` load `core_upd_val` at any time, and they win over a host write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 write, 0 read |
| host_addr | input | 2 | Register select |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, combinational |
| drq | output | 1 | Data request |
| intrq | output | 1 | Interrupt request |
| cmd_start | output | 1 | One-cycle pulse on an accepted command |
| cmd_code | output | 8 | Latched command byte |
| force_term | output | 1 | One-cycle pulse when Force Interrupt stops a running command |
| core_rx_valid | input | 1 | Core delivers a byte read from disk |
| core_rx_byte | input | 8 | Byte delivered by the core |
| core_tx_take | input | 1 | Core takes the data register byte for disk |
| data_byte | output | 8 | Data register contents for the core |
| core_done | input | 1 | Command completion strobe |
| core_flags | input | 4 | Result flags for status bits 6..3 |
| core_upd_val | input | 8 | Value for core track/sector loads |
| core_trk_load | input | 1 | Core loads the track register |
| core_sec_load | input | 1 | Core loads the sector register |
| track_val | output | 8 | Track register |
| sector_val | output | 8 | Sector register |
| drv_index | input | 1 | Index pulse, active high |
| drv_ready | input | 1 | Drive ready, active high |
| drv_track0 | input | 1 | Head at track 0, active high |

## Verification
Register reads are combinational. They return the state from before the clock edge that ends the access, so the bench samples `host_rdata` shortly after driving the read and before that edge. Every other result is registered and due at the first rising edge after the stimulus. This covers Busy, DRQ, Lost Data, INTRQ, the start and terminate pulses, and the response to index and ready edges. The bench drives and samples on falling edges and checks each result in the half-cycle right after that rising edge. The one-cycle `cmd_start` and `force_term` pulses are checked there before they drop.

// File: rtl/fdc_hostif_pkg.sv
package fdc_hostif_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2;
  localparam int FLAG_W = 4;              // status bits 6..3
  localparam int COND_W = 3;              // event-armed interrupt conditions
  localparam int IMM_BIT = 3;             // immediate interrupt condition bit
  localparam logic [3:0] FI_OPCODE = 4'hD;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STAT_CMD = 2'b00,
    SEL_TRACK    = 2'b01,
    SEL_SECTOR   = 2'b10,
    SEL_DATA     = 2'b11
  } reg_sel_e;

  function automatic logic is_force_irq(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1 -: 4] == FI_OPCODE;
  endfunction

  function automatic logic [BYTE_W-1:0] pack_status(
    input logic              not_ready,
    input logic [FLAG_W-1:0] flags,
    input logic              type1,
    input logic              trk0,
    input logic              idx,
    input logic              lost,
    input logic              drq,
    input logic              busy);
    logic lo2, lo1;
    lo2 = type1 ? trk0 : lost;
    lo1 = type1 ? idx  : drq;
    return {not_ready, flags, lo2, lo1, busy};
  endfunction
endpackage

// File: rtl/fdc_hostif_decode.sv
module fdc_hostif_decode
  import fdc_hostif_pkg::*;
(
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              cmd_wr_o,
  output logic              stat_rd_o,
  output logic              trk_wr_o,
  output logic              sec_wr_o,
  output logic              dat_wr_o,
  output logic              dat_rd_o
);
  reg_sel_e rsel;
  logic     wr_stb, rd_stb;

  assign rsel   = reg_sel_e'(addr_i);
  assign wr_stb = sel_i && wr_i;
  assign rd_stb = sel_i && !wr_i;

  always_comb begin
    cmd_wr_o  = wr_stb && (rsel == SEL_STAT_CMD);
    stat_rd_o = rd_stb && (rsel == SEL_STAT_CMD);
    trk_wr_o  = wr_stb && (rsel == SEL_TRACK);
    sec_wr_o  = wr_stb && (rsel == SEL_SECTOR);
    dat_wr_o  = wr_stb && (rsel == SEL_DATA);
    dat_rd_o  = rd_stb && (rsel == SEL_DATA);
  end
endmodule

// File: rtl/fdc_hostif_regs.sv
module fdc_hostif_regs
  import fdc_hostif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              clr_stat_i,
  input  logic              trk_wr_i,
  input  logic              sec_wr_i,
  input  logic              dat_wr_i,
  input  logic              dat_rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              core_rx_i,
  input  logic [BYTE_W-1:0] core_rx_byte_i,
  input  logic              core_take_i,
  input  logic [BYTE_W-1:0] core_val_i,
  input  logic              core_trk_ld_i,
  input  logic              core_sec_ld_i,
  output logic [BYTE_W-1:0] trk_o,
  output logic [BYTE_W-1:0] sec_o,
  output logic [BYTE_W-1:0] dat_o,
  output logic              drq_o,
  output logic              lost_o
);
  logic [BYTE_W-1:0] trk_q, sec_q, dat_q;
  logic              drq_q, lost_q;
  logic              core_evt, host_dat_acc, overrun;

  // named events for assertions
  assign core_evt     = core_rx_i || core_take_i;
  assign host_dat_acc = dat_wr_i || dat_rd_i;
  assign overrun      = core_evt && drq_q && !host_dat_acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trk_q <= '0;
      sec_q <= '0;
      dat_q <= '0;
    end else begin
      if (core_trk_ld_i)          trk_q <= core_val_i;
      else if (trk_wr_i && !busy_i) trk_q <= wdata_i;
      if (core_sec_ld_i)          sec_q <= core_val_i;
      else if (sec_wr_i && !busy_i) sec_q <= wdata_i;
      if (core_rx_i)              dat_q <= core_rx_byte_i;
      else if (dat_wr_i)          dat_q <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drq_q  <= 1'b0;
      lost_q <= 1'b0;
    end else if (clr_stat_i) begin
      drq_q  <= 1'b0;
      lost_q <= 1'b0;
    end else if (core_evt) begin
      drq_q <= 1'b1;
      if (overrun) lost_q <= 1'b1;
    end else if (host_dat_acc) begin
      drq_q <= 1'b0;
    end
  end

  assign trk_o  = trk_q;
  assign sec_o  = sec_q;
  assign dat_o  = dat_q;
  assign drq_o  = drq_q;
  assign lost_o = lost_q;

  assert_drq_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_evt && !clr_stat_i) |=> drq_q);
  assert_drq_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_dat_acc && !core_evt && !clr_stat_i) |=> !drq_q);
  assert_lost_needs_drq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_q) |-> $past(drq_q));
  assert_trk_busy_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && trk_wr_i && !core_trk_ld_i) |=> $stable(trk_q));
  assert_sec_busy_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && sec_wr_i && !core_sec_ld_i) |=> $stable(sec_q));
endmodule

// File: rtl/fdc_hostif_ctrl.sv
module fdc_hostif_ctrl
  import fdc_hostif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr_i,
  input  logic              stat_rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              core_done_i,
  input  logic [FLAG_W-1:0] core_flags_i,
  input  logic              drv_index_i,
  input  logic              drv_ready_i,
  output logic              busy_o,
  output logic              type1_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              intrq_o,
  output logic [BYTE_W-1:0] cmd_o,
  output logic              start_o,
  output logic              term_o,
  output logic              clr_stat_o
);
  logic              busy_q, type1_q, intrq_q, imm_q, start_q, term_q;
  logic              idx_prev, rdy_prev;
  logic [FLAG_W-1:0] flags_q;
  logic [COND_W-1:0] arm_q;
  logic [BYTE_W-1:0] cmd_q;

  // named events
  logic fi_acc, nc_acc, cmd_load, idle_fi, done_acc;
  logic idx_rise, rdy_fall, rdy_rise, cond_hit;

  assign fi_acc   = cmd_wr_i && is_force_irq(wdata_i);
  assign nc_acc   = cmd_wr_i && !is_force_irq(wdata_i) && !busy_q;
  assign cmd_load = fi_acc || nc_acc;
  assign idle_fi  = fi_acc && !busy_q;
  assign done_acc = core_done_i && busy_q && !cmd_load;
  assign idx_rise = drv_index_i && !idx_prev;
  assign rdy_fall = !drv_ready_i && rdy_prev;
  assign rdy_rise = drv_ready_i && !rdy_prev;
  assign cond_hit = (arm_q[2] && idx_rise) || (arm_q[1] && rdy_fall) ||
                    (arm_q[0] && rdy_rise);
  assign clr_stat_o = nc_acc || idle_fi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      type1_q  <= 1'b1;
      flags_q  <= '0;
      intrq_q  <= 1'b0;
      imm_q    <= 1'b0;
      arm_q    <= '0;
      cmd_q    <= '0;
      start_q  <= 1'b0;
      term_q   <= 1'b0;
      idx_prev <= 1'b0;
      rdy_prev <= 1'b0;
    end else begin
      start_q  <= nc_acc;
      term_q   <= fi_acc && busy_q;
      idx_prev <= drv_index_i;
      rdy_prev <= drv_ready_i;

      if (cmd_load) begin
        cmd_q <= wdata_i;
        arm_q <= fi_acc ? wdata_i[COND_W-1:0] : '0;
        imm_q <= fi_acc && wdata_i[IMM_BIT];
      end

      if (fi_acc)        busy_q <= 1'b0;
      else if (nc_acc)   busy_q <= 1'b1;
      else if (done_acc) busy_q <= 1'b0;

      if (nc_acc)        type1_q <= !wdata_i[BYTE_W-1];
      else if (idle_fi)  type1_q <= 1'b1;

      if (clr_stat_o)    flags_q <= '0;
      else if (done_acc) flags_q <= core_flags_i;

      if (cmd_load)                  intrq_q <= fi_acc && wdata_i[IMM_BIT];
      else if (done_acc || cond_hit) intrq_q <= 1'b1;
      else if (stat_rd_i && !imm_q)  intrq_q <= 1'b0;
    end
  end

  assign busy_o  = busy_q;
  assign type1_o = type1_q;
  assign flags_o = flags_q;
  assign intrq_o = intrq_q;
  assign cmd_o   = cmd_q;
  assign start_o = start_q;
  assign term_o  = term_q;

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> busy_q);
  assert_busy_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_i && busy_q && !is_force_irq(wdata_i)) |=> (!start_q && $stable(cmd_q)));
  assert_done_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_acc |=> (intrq_q && !busy_q));
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_i && !imm_q && !cmd_load && !done_acc && !cond_hit) |=> !intrq_q);
  assert_term_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    term_q |-> !busy_q);
  assert_imm_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    imm_q |-> intrq_q);
  assert_cond_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_hit && !cmd_load) |=> intrq_q);
endmodule

// File: rtl/fdc_hostif.sv
module fdc_hostif
  import fdc_hostif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              drq,
  output logic              intrq,
  output logic              cmd_start,
  output logic [BYTE_W-1:0] cmd_code,
  output logic              force_term,
  input  logic              core_rx_valid,
  input  logic [BYTE_W-1:0] core_rx_byte,
  input  logic              core_tx_take,
  output logic [BYTE_W-1:0] data_byte,
  input  logic              core_done,
  input  logic [FLAG_W-1:0] core_flags,
  input  logic [BYTE_W-1:0] core_upd_val,
  input  logic              core_trk_load,
  input  logic              core_sec_load,
  output logic [BYTE_W-1:0] track_val,
  output logic [BYTE_W-1:0] sector_val,
  input  logic              drv_index,
  input  logic              drv_ready,
  input  logic              drv_track0
);
  logic cmd_wr, stat_rd, trk_wr, sec_wr, dat_wr, dat_rd;
  logic busy, type1, clr_stat, lost;
  logic [FLAG_W-1:0] flags;
  logic [BYTE_W-1:0] status;

  fdc_hostif_decode u_decode (
    .sel_i(host_sel), .wr_i(host_wr), .addr_i(host_addr),
    .cmd_wr_o(cmd_wr), .stat_rd_o(stat_rd), .trk_wr_o(trk_wr),
    .sec_wr_o(sec_wr), .dat_wr_o(dat_wr), .dat_rd_o(dat_rd)
  );

  fdc_hostif_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_wr_i(cmd_wr), .stat_rd_i(stat_rd),
    .wdata_i(host_wdata), .core_done_i(core_done), .core_flags_i(core_flags),
    .drv_index_i(drv_index), .drv_ready_i(drv_ready),
    .busy_o(busy), .type1_o(type1), .flags_o(flags), .intrq_o(intrq),
    .cmd_o(cmd_code), .start_o(cmd_start), .term_o(force_term),
    .clr_stat_o(clr_stat)
  );

  fdc_hostif_regs u_regs (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .clr_stat_i(clr_stat),
    .trk_wr_i(trk_wr), .sec_wr_i(sec_wr), .dat_wr_i(dat_wr), .dat_rd_i(dat_rd),
    .wdata_i(host_wdata), .core_rx_i(core_rx_valid), .core_rx_byte_i(core_rx_byte),
    .core_take_i(core_tx_take), .core_val_i(core_upd_val),
    .core_trk_ld_i(core_trk_load), .core_sec_ld_i(core_sec_load),
    .trk_o(track_val), .sec_o(sector_val), .dat_o(data_byte),
    .drq_o(drq), .lost_o(lost)
  );

  assign status = pack_status(!drv_ready, flags, type1, drv_track0, drv_index,
                              lost, drq, busy);

  always_comb begin
    unique case (reg_sel_e'(host_addr))
      SEL_STAT_CMD: host_rdata = status;
      SEL_TRACK:    host_rdata = track_val;
      SEL_SECTOR:   host_rdata = sector_val;
      default:      host_rdata = data_byte;
    endcase
  end
endmodule

// File: tb/fdc_hostif_bench.sv
module fdc_hostif_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, host_sel, host_wr;
  logic [1:0] host_addr;
  logic [7:0] host_wdata, host_rdata, cmd_code, core_rx_byte, data_byte;
  logic [7:0] core_upd_val, track_val, sector_val;
  logic       drq, intrq, cmd_start, force_term, core_rx_valid, core_tx_take;
  logic       core_done, core_trk_load, core_sec_load, drv_index, drv_ready, drv_track0;
  logic [3:0] core_flags;

  fdc_hostif u_fdc_hostif (.*);

  int checks = 0, errors = 0;
  logic [7:0] exp_dat;
  logic       exp_drq, exp_lost;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status(input logic nr, input logic [3:0] fl,
      input logic t1, input logic tz, input logic ix, input logic ld,
      input logic dq, input logic bz);
    logic [7:0] s;
    s = 8'h00;
    s[7] = nr;
    s[6:3] = fl;
    s[0] = bz;
    if (t1) begin s[2] = tz; s[1] = ix; end
    else    begin s[2] = ld; s[1] = dq; end
    return s;
  endfunction

  task automatic cyc;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
    cyc();
    host_sel = 0; host_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    host_sel = 1; host_wr = 0; host_addr = a;
    #1 v = host_rdata;
    cyc();
    host_sel = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h1F0D5EED));
    rst_n = 0; host_sel = 0; host_wr = 0; host_addr = 0; host_wdata = 0;
    core_rx_valid = 0; core_rx_byte = 0; core_tx_take = 0; core_done = 0;
    core_flags = 0; core_upd_val = 0; core_trk_load = 0; core_sec_load = 0;
    drv_index = 0; drv_ready = 1; drv_track0 = 0;
    repeat (3) cyc();
    rst_n = 1;
    cyc();

    // reset state
    chk("R2 reset drq", {7'd0, drq}, 8'h00);
    chk("R7 reset intrq", {7'd0, intrq}, 8'h00);
    rd(2'b00, v); chk("R2 reset status", v, exp_status(0, 0, 1, 0, 0, 0, 0, 0));

    // R1 register map
    wr(2'b01, 8'h21); wr(2'b10, 8'h05); wr(2'b11, 8'hA5);
    rd(2'b01, v); chk("R1 track", v, 8'h21);
    rd(2'b10, v); chk("R1 sector", v, 8'h05);
    rd(2'b11, v); chk("R1 data", v, 8'hA5);
    exp_dat = 8'hA5;

    // R3 accepted command, R2 status not command
    wr(2'b00, 8'h88);
    chk("R3 start pulse", {7'd0, cmd_start}, 8'h01);
    chk("R3 cmd code", cmd_code, 8'h88);
    rd(2'b00, v); chk("R2 status not cmd", v, exp_status(0, 0, 0, 0, 0, 0, 0, 1));
    chk("R3 start one cycle", {7'd0, cmd_start}, 8'h00);

    // R12 busy writes ignored, core loads work
    wr(2'b01, 8'h33); wr(2'b10, 8'h44);
    rd(2'b01, v); chk("R12 track busy", v, 8'h21);
    rd(2'b10, v); chk("R12 sector busy", v, 8'h05);
    core_upd_val = 8'h22; core_trk_load = 1; cyc(); core_trk_load = 0;
    core_upd_val = 8'h06; core_sec_load = 1; cyc(); core_sec_load = 0;
    chk("R12 core track load", track_val, 8'h22);
    chk("R12 core sector load", sector_val, 8'h06);

    // R4 rejected command while busy
    wr(2'b00, 8'h20);
    chk("R4 no start", {7'd0, cmd_start}, 8'h00);
    chk("R4 code kept", cmd_code, 8'h88);

    // R5/R6 random handshake traffic while busy
    exp_drq = 0; exp_lost = 0;
    for (int i = 0; i < 300; i++) begin
      int op, co;
      logic [7:0] b, w, rv;
      logic acc;
      op = $urandom_range(0, 4); co = $urandom_range(0, 2);
      b = 8'($urandom); w = 8'($urandom);
      core_rx_valid = (co == 1); core_rx_byte = b; core_tx_take = (co == 2);
      if (op == 1 || op == 2 || op == 3) begin
        host_sel = 1; host_wr = (op == 2); host_wdata = w;
        host_addr = (op == 3) ? 2'b00 : 2'b11;
      end
      #1 rv = host_rdata;
      cyc();
      host_sel = 0; host_wr = 0; core_rx_valid = 0; core_tx_take = 0;
      if (op == 1) chk("R1 data read", rv, exp_dat);
      if (op == 3) chk("R5 R6 status", rv, exp_status(0, 0, 0, 0, 0, exp_lost, exp_drq, 1));
      acc = (op == 1 || op == 2);
      if (co != 0) begin
        if (exp_drq && !acc) exp_lost = 1;
        exp_drq = 1;
      end else if (acc) exp_drq = 0;
      if (co == 1) exp_dat = b;
      else if (op == 2) exp_dat = w;
      chk("R5 drq", {7'd0, drq}, {7'd0, exp_drq});
      chk("R6 data reg", data_byte, exp_dat);
    end

    // R7 completion
    core_flags = 4'b1010; core_done = 1; cyc(); core_done = 0;
    chk("R7 intrq on done", {7'd0, intrq}, 8'h01);
    rd(2'b00, v); chk("R7 flags latched", v, exp_status(0, 4'b1010, 0, 0, 0, exp_lost, exp_drq, 0));
    chk("R7 read clears intrq", {7'd0, intrq}, 8'h00);

    // R9 force interrupt while idle
    drv_track0 = 1;
    wr(2'b00, 8'hD0);
    chk("R9 no term pulse", {7'd0, force_term}, 8'h00);
    chk("R9 drq cleared", {7'd0, drq}, 8'h00);
    rd(2'b00, v); chk("R9 type1 status", v, exp_status(0, 0, 1, 1, 0, 0, 0, 0));
    chk("R10 zero cond no intrq", {7'd0, intrq}, 8'h00);

    // R8 force interrupt while busy
    wr(2'b00, 8'h80);
    core_rx_byte = 8'h11; core_rx_valid = 1; cyc(); core_rx_valid = 0;
    core_rx_byte = 8'h12; core_rx_valid = 1; cyc(); core_rx_valid = 0;
    wr(2'b00, 8'hD0);
    chk("R8 term pulse", {7'd0, force_term}, 8'h01);
    rd(2'b00, v); chk("R8 status kept", v, exp_status(0, 0, 0, 0, 0, 1, 1, 0));
    chk("R8 drq kept", {7'd0, drq}, 8'h01);
    rd(2'b11, v); chk("R6 overrun byte", v, 8'h12);

    // R10 immediate interrupt held
    wr(2'b00, 8'hD8);
    chk("R10 immediate intrq", {7'd0, intrq}, 8'h01);
    rd(2'b00, v); chk("R10 status", v, exp_status(0, 0, 1, 1, 0, 0, 0, 0));
    chk("R10 held after read", {7'd0, intrq}, 8'h01);
    wr(2'b00, 8'h03);
    chk("R10 cleared by command", {7'd0, intrq}, 8'h00);
    rd(2'b00, v); chk("R3 type1 busy", v, exp_status(0, 0, 1, 1, 0, 0, 0, 1));
    core_flags = 4'b0000; core_done = 1; cyc(); core_done = 0;
    chk("R7 type1 done", {7'd0, intrq}, 8'h01);
    rd(2'b00, v);
    chk("R7 cleared again", {7'd0, intrq}, 8'h00);

    // R11 event conditions
    wr(2'b00, 8'hD4);
    drv_index = 1; cyc();
    chk("R11 index edge", {7'd0, intrq}, 8'h01);
    rd(2'b00, v); chk("R11 status index", v, exp_status(0, 0, 1, 1, 1, 0, 0, 0));
    drv_index = 0;
    wr(2'b00, 8'hD2);
    drv_ready = 0; cyc();
    chk("R11 ready lost", {7'd0, intrq}, 8'h01);
    rd(2'b00, v); chk("R11 status not ready", v, exp_status(1, 0, 1, 1, 0, 0, 0, 0));
    wr(2'b00, 8'hD1);
    cyc();
    chk("R11 no spurious", {7'd0, intrq}, 8'h00);
    drv_ready = 1; cyc();
    chk("R11 ready gained", {7'd0, intrq}, 8'h01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule